// File: doc/BRIEF.md
# Dual-Channel Serial Port

This block holds two asynchronous serial channels that share one command word. Each channel has a one-entry transmit holding register in front of a shift register, and a receive shifter that fills a one-entry receive data register. Transmit and receive on each channel run from their own 15-bit divisors. Both divisors sit in the channel's rate register. For a target rate the divisor is `clock_hz / rate - 1`, so each serial bit lasts `divisor + 1` clock cycles.

Software reaches the block through a single-cycle register port with eight word addresses:

| Address | Register |
|---|---|
| 0 | command |
| 1 | receive data, channel 0 |
| 2 | transmit data, channel 0 |
| 3 | rate, channel 0 |
| 4 | receive data, channel 1 |
| 5 | transmit data, channel 1 |
| 6 | rate, channel 1 |
| 7 | status |

The serial byte path has no valid/ready pins. Flow control goes through status bits instead:
- A transmit write is accepted only while the channel's tx-ready bit is 1. A write made while it is 0 is lost.
- A received byte that finds rx-ready still set replaces the held byte and raises overrun.

The status word also drives the `irq_status` output, which feeds an interrupt controller outside the block.

A frame is built as follows:
- one low start bit;
- eight data bits, least significant bit first;
- an optional parity bit;
- one high stop bit.

Top module: `twin_uart`

## Requirements
- R1: After reset:
  - both serial outputs are high and both RTS outputs are low;
  - the command word reads 0;
  - the status word reads 0x0018_6000, which means tx-ready and tx-empty are set on both channels and every other bit is clear.
- R2: With tx enable set, a written byte is sent as a low start bit, eight data bits LSB first and a high stop bit. Every bit lasts tx-divisor + 1 cycles. While tx enable is clear, the byte stays held and the line stays high. Tx enable is command bit 6 for channel 0 and bit 12 for channel 1.
- R3: With parity enable set, a parity bit is inserted between the data bits and the stop bit. Parity enable is bit 8 for channel 0 and bit 14 for channel 1. The parity bit makes the count of ones even when the even-select bit is 1 (bit 9 or bit 15), and odd when it is 0.
- R4: Tx-ready is clear while the holding register is full, and a write made then is dropped. Tx-empty is set only when both the holding register and the shifter are empty. Tx-empty implies tx-ready. For channel 0, tx-ready is status bit 14 and tx-empty is bit 13. For channel 1 they are bits 20 and 19.
- R5: A frame starts only while the channel's `cts` input is high, unless command bit 2 is set. Bit 2 lets both transmitters start regardless of `cts`.
- R6: While a channel's break bit is set, its serial output is held low. The break bit is command bit 4 for channel 0 and bit 10 for channel 1.
- R7: With rx enable set, a received frame is sampled at mid-bit using the rx divisor. It then appears in bits 7..0 of the receive data register and sets rx-ready. Reading that register clears rx-ready. Rx enable is command bit 5 for channel 0 and bit 11 for channel 1. Rx-ready is status bit 15 for channel 0 and bit 21 for channel 1.
- R8: A byte that completes while rx-ready is still set raises overrun (status bit 12 or 18) and replaces the held byte. Overrun stays set until a status write with a 1 in that bit.
- R9: A stop bit sampled low raises frame error (status bit 11 or 17). The byte is still delivered. Frame error stays set until a status write with a 1 in that bit.
- R10: While command bit 3 is set, each channel's transmit line feeds its own receiver, and both external serial outputs stay high.
- R11: While command bit 1 is set, both channels are held cleared:
  - receive flags are clear;
  - the transmitters are idle and empty;
  - the command and rate registers keep their contents.
- R12: The RTS output of a channel follows its RTS command bit: bit 7 for channel 0 and bit 13 for channel 1.
- R13: The rate register stores the tx divisor in bits 14..0 and the rx divisor in bits 30..16. Bits 15 and 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears rx-ready on a receive data read) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rxd | input | 2 | Serial inputs, one per channel |
| cts | input | 2 | Clear-to-send, active high, one per channel |
| txd | output | 2 | Serial outputs, idle high |
| rts | output | 2 | Request-to-send, one per channel |
| irq_status | output | 32 | Status word for the interrupt controller |

## Verification
The following rules are checked on every cycle, because each one relates the command word, the status word and the serial outputs directly:
- break forces the line low;
- loopback keeps the external lines high;
- tx-empty implies tx-ready;
- overrun and frame error stay set until cleared;
- soft reset clears rx-ready.

Frame shape, bit timing, parity polarity and the CTS gate span many cycles, so only the directed scenarios can show them. The same holds for dropped writes, overwrite-on-overrun and the loopback round trip.

// File: rtl/twin_uart_pkg.sv
package twin_uart_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RATE_W = 15;
  localparam int unsigned LANES  = 2;

  // command word layout; the lane field repeats with a fixed stride
  localparam int unsigned CMD_SOFT_RST  = 1;
  localparam int unsigned CMD_CTS_FORCE = 2;
  localparam int unsigned CMD_LOOP      = 3;
  localparam int unsigned CTL_LSB       = 4;
  localparam int unsigned STAT_LSB      = 11;
  localparam int unsigned LANE_STRIDE   = 6;
  localparam int unsigned RX_RATE_LSB   = 16;
  localparam logic [WORD_W-1:0] CMD_KEEP  = 32'h0000_FFFE;
  localparam logic [WORD_W-1:0] RATE_KEEP = 32'h7FFF_7FFF;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD   = 3'd0,
    SEL_STAT  = 3'd7
  } reg_sel_e;

  // field order follows the command word from high bit to low bit
  typedef struct packed {
    logic par_even;
    logic par_en;
    logic rts;
    logic tx_en;
    logic rx_en;
    logic brk;
  } lane_ctl_t;

  // field order follows the status word from high bit to low bit
  typedef struct packed {
    logic rx_full;
    logic tx_free;
    logic tx_idle;
    logic rx_ovr;
    logic rx_ferr;
  } lane_stat_t;

  localparam int unsigned CTL_W  = $bits(lane_ctl_t);
  localparam int unsigned STAT_W = $bits(lane_stat_t);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_REARM
  } rx_state_e;

  // per-lane register offsets: 0 receive data, 1 transmit data, 2 rate
  function automatic logic [ADDR_W-1:0] lane_reg(input int lane, input int off);
    return ADDR_W'(1 + 3 * lane + off);
  endfunction
endpackage

// File: rtl/twin_uart_tx.sv
module twin_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DIV_W-1:0]  div,
  input  logic              start_ok,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              line,
  output logic              hold_full,
  output logic              busy
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic               hold_v;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [DIV_W-1:0]   tick_q;
  logic               busy_q;
  logic               par_bit;

  assign par_bit = par_even ? ^hold_q : ~^hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
      busy_q <= 1'b0;
    end else if (clr) begin
      hold_v <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr && !hold_v) begin
        hold_q <= wdata;
        hold_v <= 1'b1;
      end
      if (!busy_q) begin
        if (hold_v && start_ok) begin
          sh_q   <= {1'b1, (par_en ? par_bit : 1'b1), hold_q, 1'b0};
          left_q <= par_en ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
          tick_q <= div;
          busy_q <= 1'b1;
          hold_v <= 1'b0;
        end
      end else if (tick_q == '0) begin
        tick_q <= div;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        tick_q <= tick_q - 1'b1;
      end
    end
  end

  assign line      = busy_q ? sh_q[0] : 1'b1;
  assign hold_full = hold_v;
  assign busy      = busy_q;
endmodule

// File: rtl/twin_uart_rx.sv
module twin_uart_rx
  import twin_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              line,
  input  logic              take,
  input  logic              clr_ovr,
  input  logic              clr_ferr,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ovr,
  output logic              ferr
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 3);

  rx_state_e         st_q;
  logic [DIV_W-1:0]  tick_q;
  logic [CNT_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              ovr_q;
  logic              ferr_q;
  logic [CNT_W-1:0]  stop_idx;

  assign stop_idx = par_en ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tick_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else if (clr) begin
      st_q   <= RX_IDLE;
      tick_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (take)     full_q <= 1'b0;
      if (clr_ovr)  ovr_q  <= 1'b0;
      if (clr_ferr) ferr_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (rx_en && !line) begin
            st_q   <= RX_START;
            tick_q <= div >> 1;
          end
        end
        RX_START: begin
          if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
          end else if (!line) begin
            st_q   <= RX_BITS;
            tick_q <= div;
            idx_q  <= '0;
          end else begin
            st_q <= RX_IDLE;
          end
        end
        RX_BITS: begin
          if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
          end else begin
            tick_q <= div;
            idx_q  <= idx_q + 1'b1;
            if (idx_q < CNT_W'(DATA_W)) sh_q <= {line, sh_q[DATA_W-1:1]};
            if (idx_q == stop_idx) begin
              data_q <= sh_q;
              full_q <= 1'b1;
              if (full_q && !take) ovr_q <= 1'b1;
              if (!line) ferr_q <= 1'b1;
              st_q <= RX_REARM;
            end
          end
        end
        default: begin
          if (line) st_q <= RX_IDLE;
        end
      endcase
    end
  end

  assign data = data_q;
  assign full = full_q;
  assign ovr  = ovr_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/twin_uart_lane.sv
module twin_uart_lane
  import twin_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  lane_ctl_t         ctl,
  input  logic              loop,
  input  logic              cts_force,
  input  logic [DIV_W-1:0]  tx_div,
  input  logic [DIV_W-1:0]  rx_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_take,
  input  logic              clr_ovr,
  input  logic              clr_ferr,
  input  logic              rxd,
  input  logic              cts,
  output logic              txd,
  output logic              rts,
  output logic [DATA_W-1:0] rx_data,
  output lane_stat_t        stat
);
  logic       tx_line;
  logic       wire_line;
  logic       hold_full;
  logic       tx_busy;
  logic [1:0] sync_q;
  logic       rx_ovr;
  logic       rx_ferr;
  logic       rx_full;

  twin_uart_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .div       (tx_div),
    .start_ok  (ctl.tx_en && (cts || cts_force) && !ctl.brk),
    .par_en    (ctl.par_en),
    .par_even  (ctl.par_even),
    .wr        (tx_wr),
    .wdata     (tx_data),
    .line      (tx_line),
    .hold_full (hold_full),
    .busy      (tx_busy)
  );

  assign wire_line = ctl.brk ? 1'b0 : tx_line;
  assign txd       = loop ? 1'b1 : wire_line;
  assign rts       = ctl.rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], (loop ? wire_line : rxd)};
  end

  twin_uart_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .div      (rx_div),
    .rx_en    (ctl.rx_en),
    .par_en   (ctl.par_en),
    .line     (sync_q[1]),
    .take     (rx_take),
    .clr_ovr  (clr_ovr),
    .clr_ferr (clr_ferr),
    .data     (rx_data),
    .full     (rx_full),
    .ovr      (rx_ovr),
    .ferr     (rx_ferr)
  );

  always_comb begin
    stat.rx_full = rx_full;
    stat.tx_free = !hold_full;
    stat.tx_idle = !hold_full && !tx_busy;
    stat.rx_ovr  = rx_ovr;
    stat.rx_ferr = rx_ferr;
  end
endmodule

// File: rtl/twin_uart.sv
module twin_uart
  import twin_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LANES-1:0]  rxd,
  input  logic [LANES-1:0]  cts,
  output logic [LANES-1:0]  txd,
  output logic [LANES-1:0]  rts,
  output logic [WORD_W-1:0] irq_status
);
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] rate_q [LANES];
  logic [BYTE_W-1:0] rx_byte [LANES];
  lane_stat_t        lstat [LANES];
  logic              stat_wr;

  assign stat_wr = bus_wr && (bus_addr == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (bus_wr && bus_addr == SEL_CMD) cmd_q <= bus_wdata & CMD_KEEP;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned CB = CTL_LSB + g * LANE_STRIDE;
    localparam int unsigned SB = STAT_LSB + g * LANE_STRIDE;
    localparam logic [ADDR_W-1:0] RX_A   = lane_reg(g, 0);
    localparam logic [ADDR_W-1:0] TX_A   = lane_reg(g, 1);
    localparam logic [ADDR_W-1:0] RATE_A = lane_reg(g, 2);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rate_q[g] <= '0;
      else if (bus_wr && bus_addr == RATE_A) rate_q[g] <= bus_wdata & RATE_KEEP;
    end

    twin_uart_lane #(.DATA_W(BYTE_W), .DIV_W(RATE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (cmd_q[CMD_SOFT_RST]),
      .ctl       (lane_ctl_t'(cmd_q[CB +: CTL_W])),
      .loop      (cmd_q[CMD_LOOP]),
      .cts_force (cmd_q[CMD_CTS_FORCE]),
      .tx_div    (rate_q[g][RATE_W-1:0]),
      .rx_div    (rate_q[g][RX_RATE_LSB +: RATE_W]),
      .tx_wr     (bus_wr && bus_addr == TX_A),
      .tx_data   (bus_wdata[BYTE_W-1:0]),
      .rx_take   (bus_rd && bus_addr == RX_A),
      .clr_ovr   (stat_wr && bus_wdata[SB + 1]),
      .clr_ferr  (stat_wr && bus_wdata[SB]),
      .rxd       (rxd[g]),
      .cts       (cts[g]),
      .txd       (txd[g]),
      .rts       (rts[g]),
      .rx_data   (rx_byte[g]),
      .stat      (lstat[g])
    );
  end

  always_comb begin
    irq_status = '0;
    for (int i = 0; i < LANES; i++) begin
      irq_status[STAT_LSB + i * LANE_STRIDE +: STAT_W] = lstat[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SEL_CMD)  bus_rdata = cmd_q;
    if (bus_addr == SEL_STAT) bus_rdata = irq_status;
    for (int i = 0; i < LANES; i++) begin
      if (bus_addr == lane_reg(i, 0)) bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, rx_byte[i]};
      if (bus_addr == lane_reg(i, 2)) bus_rdata = rate_q[i];
    end
  end
endmodule

// File: rtl/twin_uart_sva.sv
module twin_uart_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [1:0]  txd,
  input logic [31:0] irq_status,
  input logic [31:0] cmd_q
);
  logic stat_wr;
  assign stat_wr = bus_wr && (bus_addr == 3'd7);

  AST_BREAK_LOW_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[4] && !cmd_q[3]) |-> !txd[0]); // R6
  AST_BREAK_LOW_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[10] && !cmd_q[3]) |-> !txd[1]); // R6
  AST_LOOP_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[3] |-> (txd == 2'b11)); // R10
  AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[13] || irq_status[19]) |-> ((!irq_status[13] || irq_status[14]) && (!irq_status[19] || irq_status[20]))); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[12] && !(stat_wr && bus_wdata[12]) && !cmd_q[1]) |=> irq_status[12]); // R8
  AST_FRAME_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[17] && !(stat_wr && bus_wdata[17]) && !cmd_q[1]) |=> irq_status[17]); // R9
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[1] |=> (!irq_status[15] && !irq_status[21] && irq_status[14] && irq_status[20])); // R11
endmodule

bind twin_uart twin_uart_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .txd        (txd),
  .irq_status (irq_status),
  .cmd_q      (cmd_q)
);

// File: tb/test_twin_uart.sv
`timescale 1ns/1ps
module test_twin_uart;
  localparam logic [31:0] IDLE_ST = 32'h0018_6000;
  localparam logic [31:0] C_BRK0 = 32'h10, C_RX0 = 32'h20, C_TX0 = 32'h40, C_RTS0 = 32'h80;
  localparam logic [31:0] C_PE0 = 32'h100, C_EV0 = 32'h200;
  localparam logic [31:0] C_RX1 = 32'h800, C_TX1 = 32'h1000, C_RTS1 = 32'h2000;
  localparam logic [31:0] C_LOOP = 32'h8, C_CTSF = 32'h4, C_SRST = 32'h2;
  localparam int P_TX0 = 8, P_RX0 = 12, P_1 = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  rxd = 2'b11, cts = 2'b11;
  logic [1:0]  txd, rts;
  logic [31:0] irq_status;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  twin_uart i_twin_uart (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .cts(cts), .txd(txd),
    .rts(rts), .irq_status(irq_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic grab_frame(input int ch, input int per, input int nbits, output logic [11:0] bits);
    int waited = 0;
    bits = '1;
    while (txd[ch] !== 1'b0 && waited < 4000) begin @(negedge clk); waited++; end
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bits[i] = txd[ch];
      if (i < nbits - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic send_frame(input int ch, input int per, input logic [7:0] b, input logic stop);
    @(negedge clk); rxd[ch] = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd[ch] = b[i]; repeat (per) @(negedge clk); end
    rxd[ch] = stop;
    repeat (per) @(negedge clk);
    rxd[ch] = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(txd === 2'b11 && rts === 2'b00, "R1 pins", {28'd0, txd, rts}, 32'hC);
    bus_read(3'd0, d); chk(d === 32'd0, "R1 command", d, 32'd0);
    bus_read(3'd7, d); chk(d === IDLE_ST, "R1 status", d, IDLE_ST);
  endtask

  task automatic t_rate;
    logic [31:0] d;
    bus_write(3'd3, 32'hFFFF_FFFF); bus_read(3'd3, d);
    chk(d === 32'h7FFF_7FFF, "R13 field layout", d, 32'h7FFF_7FFF);
    bus_write(3'd3, (32'd11 << 16) | 32'd7);
    bus_write(3'd6, (32'd5 << 16) | 32'd5);
    bus_read(3'd3, d);
    chk(d === 32'h000B_0007, "R13 split divisors", d, 32'h000B_0007);
  endtask

  task automatic t_tx_basic;
    logic [11:0] f; logic [31:0] d; int hi = 0;
    bus_write(3'd0, 32'd0);
    bus_write(3'd2, 32'hA5);
    repeat (200) begin @(negedge clk); if (txd[0] === 1'b1) hi++; end
    bus_read(3'd7, d);
    chk(hi == 200 && d[14] === 1'b0, "R2 held while disabled", {d[14], 31'(hi)}, 32'd200);
    bus_write(3'd0, C_TX0);
    grab_frame(0, P_TX0, 10, f);
    chk(f[9:0] === {1'b1, 8'hA5, 1'b0}, "R2 frame ch0", {22'd0, f[9:0]}, {22'd0, 1'b1, 8'hA5, 1'b0});
    bus_write(3'd0, C_TX1);
    bus_write(3'd5, 32'h3C);
    grab_frame(1, P_1, 10, f);
    chk(f[9:0] === {1'b1, 8'h3C, 1'b0}, "R2 frame ch1", {22'd0, f[9:0]}, {22'd0, 1'b1, 8'h3C, 1'b0});
  endtask

  task automatic t_parity;
    logic [11:0] f;
    bus_write(3'd0, C_TX0 | C_PE0 | C_EV0);
    bus_write(3'd2, 32'h07);
    grab_frame(0, P_TX0, 11, f);
    chk(f[10:0] === {2'b11, 8'h07, 1'b0}, "R3 even parity", {21'd0, f[10:0]}, {21'd0, 2'b11, 8'h07, 1'b0});
    bus_write(3'd0, C_TX0 | C_PE0);
    bus_write(3'd2, 32'h07);
    grab_frame(0, P_TX0, 11, f);
    chk(f[10:0] === {2'b10, 8'h07, 1'b0}, "R3 odd parity", {21'd0, f[10:0]}, {21'd0, 2'b10, 8'h07, 1'b0});
  endtask

  task automatic t_flags;
    logic [11:0] f1, f2; logic [31:0] d; int low = 0;
    bus_write(3'd0, C_TX0);
    fork
      begin grab_frame(0, P_TX0, 10, f1); grab_frame(0, P_TX0, 10, f2); end
      begin
        bus_write(3'd2, 32'h11);
        bus_write(3'd2, 32'h22);
        bus_read(3'd7, d);
        chk(d[14:13] === 2'b00, "R4 holding full", {30'd0, d[14:13]}, 32'd0);
        bus_write(3'd2, 32'h33);
      end
    join
    chk(f1[8:1] === 8'h11 && f2[8:1] === 8'h22, "R4 order, third write dropped",
        {16'd0, f1[8:1], f2[8:1]}, 32'h1122);
    repeat (3 * 11 * P_TX0) begin @(negedge clk); if (txd[0] !== 1'b1) low++; end
    bus_read(3'd7, d);
    chk(low == 0 && d[14:13] === 2'b11, "R4 no extra frame, empty", {d[14:13], 30'(low)}, 32'hC000_0000);
  endtask

  task automatic t_cts;
    logic [11:0] f; logic [31:0] d; int low = 0;
    cts[0] = 1'b0;
    bus_write(3'd0, C_TX0);
    bus_write(3'd2, 32'h5C);
    repeat (300) begin @(negedge clk); if (txd[0] !== 1'b1) low++; end
    bus_read(3'd7, d);
    chk(low == 0 && d[14] === 1'b0, "R5 blocked without cts", {d[14], 31'(low)}, 32'd0);
    bus_write(3'd0, C_TX0 | C_CTSF);
    grab_frame(0, P_TX0, 10, f);
    chk(f[8:1] === 8'h5C && f[0] === 1'b0, "R5 override starts frame", {24'd0, f[8:1]}, 32'h5C);
    cts[0] = 1'b1;
  endtask

  task automatic t_break;
    int bad = 0;
    bus_write(3'd0, C_TX0 | C_BRK0);
    repeat (60) begin @(negedge clk); if (txd !== 2'b10) bad++; end
    chk(bad == 0, "R6 break low", 32'(bad), 32'd0);
    bus_write(3'd0, C_TX0);
    @(negedge clk);
    chk(txd === 2'b11, "R6 break released", {30'd0, txd}, 32'd3);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    bus_write(3'd0, C_RX0 | C_RX1);
    send_frame(0, P_RX0, 8'h3C, 1'b1);
    bus_read(3'd7, d); chk(d[15] === 1'b1 && d[12:11] === 2'b00, "R7 ready ch0", d, 32'h8000);
    bus_read(3'd1, d); chk(d === 32'h3C, "R7 data ch0", d, 32'h3C);
    bus_read(3'd7, d); chk(d[15] === 1'b0, "R7 read clears", d, IDLE_ST);
    send_frame(1, P_1, 8'hC3, 1'b1);
    bus_read(3'd4, d); chk(d === 32'hC3, "R7 data ch1", d, 32'hC3);
    bus_read(3'd7, d); chk(d === IDLE_ST, "R7 status ch1 after read", d, IDLE_ST);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    send_frame(0, P_RX0, 8'h12, 1'b1);
    send_frame(0, P_RX0, 8'h34, 1'b1);
    bus_read(3'd7, d); chk(d[15] === 1'b1 && d[12] === 1'b1, "R8 overrun set", d, 32'h9000);
    bus_read(3'd1, d); chk(d === 32'h34, "R8 newest byte kept", d, 32'h34);
    repeat (20) @(negedge clk);
    bus_read(3'd7, d); chk(d[12] === 1'b1, "R8 overrun sticky", d, 32'h1000);
    bus_write(3'd7, 32'h1000);
    bus_read(3'd7, d); chk(d === IDLE_ST, "R8 overrun cleared", d, IDLE_ST);
  endtask

  task automatic t_frame_err;
    logic [31:0] d;
    send_frame(0, P_RX0, 8'h81, 1'b0);
    bus_read(3'd7, d); chk(d[11] === 1'b1 && d[15] === 1'b1, "R9 frame error", d, 32'h8800);
    bus_read(3'd1, d); chk(d === 32'h81, "R9 byte delivered", d, 32'h81);
    bus_write(3'd7, 32'h0800);
    bus_read(3'd7, d); chk(d === IDLE_ST, "R9 cleared", d, IDLE_ST);
  endtask

  task automatic t_loop;
    logic [31:0] d; int bad = 0; int n = 0;
    bus_write(3'd3, (32'd7 << 16) | 32'd7);
    bus_write(3'd0, C_LOOP | C_TX0 | C_RX0);
    bus_write(3'd2, 32'h5A);
    while (irq_status[15] !== 1'b1 && n < 400) begin
      @(negedge clk); n++; if (txd !== 2'b11) bad++;
    end
    chk(bad == 0, "R10 external lines high", 32'(bad), 32'd0);
    bus_read(3'd1, d); chk(d === 32'h5A, "R10 looped byte", d, 32'h5A);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d; int n = 0;
    bus_write(3'd2, 32'h66);
    while (irq_status[15] !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    bus_write(3'd0, C_LOOP | C_TX0 | C_RX0 | C_SRST);
    bus_read(3'd7, d); chk(d === IDLE_ST, "R11 flags cleared", d, IDLE_ST);
    bus_read(3'd3, d); chk(d === 32'h0007_0007, "R11 rate kept", d, 32'h0007_0007);
    bus_read(3'd0, d);
    chk(d === (C_LOOP | C_TX0 | C_RX0 | C_SRST), "R11 command kept", d, C_LOOP | C_TX0 | C_RX0 | C_SRST);
    bus_write(3'd0, 32'd0);
  endtask

  task automatic t_rts;
    bus_write(3'd0, C_RTS0 | C_RTS1);
    chk(rts === 2'b11, "R12 both rts", {30'd0, rts}, 32'd3);
    bus_write(3'd0, C_RTS1);
    chk(rts === 2'b10, "R12 ch1 only", {30'd0, rts}, 32'd2);
    bus_write(3'd0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_tx_basic();
    t_parity();
    t_flags();
    t_cts();
    t_break();
    t_rx();
    t_overrun();
    t_frame_err();
    t_loop();
    t_soft_reset();
    t_rts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule